// File: doc/BRIEF.md
# Wireless security key cache

This block holds the per-station cipher keys used by a wireless MAC's receive path, together with the station address each key belongs to. A host writes each table entry as eight 32-bit words: five key words, one type/control word and two address words. Words come in even/odd pairs, and each pair lands in one 64-bit storage row. The even word is held in a staging register, and the row is committed when the matching odd word arrives. A clear command wipes an entry. A separate update port, driven by the MAC, owns the power-management bit of each entry.

The receive side presents a 48-bit address on the lookup port. One cycle later the block returns the lowest matching entry index with its cipher type and the 128 bits of key material, or a miss. Addresses are stored shifted right by one bit. A unicast flag takes the place of the dropped group bit, so unicast keys and group keys for the same station prefix can coexist. When companion integrity keys are enabled, a TKIP entry at index N reserves entry N+COMP_OFF for its integrity key, and that companion entry never answers a lookup.

Top module: `wsec_key_cache`

## Requirements
- R1: An even-word host write (word select bit 0 = 0) only stages its data, and the stored row reads back unchanged. The following odd-word write to the same entry and row commits both halves together in one clock.
- R2: An odd-word write that has no staged even word for the same entry and row still commits its own half and leaves the stored even half unchanged. host_fault is high in the cycle after that write.
- R3: Host writes are masked on storage. Key word 1 (word select 1), key word 3 (word select 3) and the address-high word (word select 7) keep only bits 15:0 and read back with bits 31:16 at zero. The type word (word select 5) keeps bits 7:4 and 2:0, and bits 31:8 read back as zero.
- R4: In the type word, bits 2:0 hold the cipher code: 0 clear, 1 WEP-40, 2 WEP-104, 3 WEP-128, 4 TKIP, 5 AES-OCB, 6 AES-CCM. Bits 7:4 hold the U-APSD access-category bits. Bit 3 is the power-management bit. Host writes never change bit 3; only the pm update port or a clear changes it.
- R5: A host write, clear or read at an index of NUM_ENTRIES or more changes no stored state. For writes and clears, host_fault is high in the cycle after the command. A read at such an index returns zero.
- R6: With companion keys enabled, a type-word write with cipher code TKIP to an index N where N+COMP_OFF >= NUM_ENTRIES is rejected as a whole row: both halves stay unchanged and host_fault pulses.
- R7: A clear zeroes all eight words of the entry, including the power-management bit. If the entry held TKIP, key words 0 to 4 of its companion entry N+COMP_OFF are zeroed as well, and the companion's type and address words are kept.
- R8: Address word 6 stores address bits 32:1. Address word 7 stores bits 47:33 in bits 14:0 and the unicast flag in bit 15. An entry matches a lookup address A when its cipher code is not clear, its stored address equals A[47:1], and its unicast flag equals the inverse of A[0].
- R9: lk_valid is high exactly in the cycle after lk_req. When several entries match, the lowest index is returned, with its cipher code and key material {w4, w3[15:0], w2, w1[15:0], w0}.
- R10: With companion keys enabled, entry N+COMP_OFF never matches while entry N holds cipher TKIP. It may match again once entry N holds any other cipher.
- R11: On a miss, lk_hit is low and lk_idx, lk_cipher and lk_key are all zero.
- R12: When clr_en and wr_en are high in the same cycle, the clear is performed and the host write is dropped entirely, staging included.
- R13: After reset every stored word reads zero, host_fault is low and no lookup hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host word write strobe |
| wr_idx | input | IDX_W | Entry index of the write |
| wr_word | input | 3 | Word select within the entry (bit 0 odd/even, bits 2:1 row) |
| wr_data | input | 32 | Write data |
| clr_en | input | 1 | Clear-entry command |
| clr_idx | input | IDX_W | Entry to clear |
| pm_en | input | 1 | Power-management bit update strobe |
| pm_idx | input | IDX_W | Entry whose power-management bit is updated |
| pm_val | input | 1 | New power-management bit value |
| rd_idx | input | IDX_W | Read entry index |
| rd_word | input | 3 | Read word select |
| rd_data | output | 32 | Committed word contents (combinational) |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 48 | Lookup address, bit 0 is the group bit |
| lk_valid | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup found an entry |
| lk_idx | output | IDX_W | Matching entry index |
| lk_cipher | output | 3 | Cipher code of the match |
| lk_key | output | 128 | Key material of the match |
| host_fault | output | 1 | Pulse after a rejected or orphan host command |

## Verification
The bench builds the block with its defaults: 128 entries, an 8-bit index and companion keys at offset 64. With this 8-bit index, indexes 128 to 255 fall outside the table, so range rejection is exercised. TKIP entries in the upper half of the table reach the companion-range rejection, and the companion lower/upper pairing covers the lookup exclusion. Station addresses are drawn from a small pool, so duplicate matches are frequent and the lowest-index priority is exercised.

// File: rtl/wkc_pkg.sv
package wkc_pkg;
   localparam int WORD_W = 32;
   localparam int ROW_W  = 64;
   localparam int ROWS   = 4;
   localparam int KEY_W  = 128;
   localparam int ADDR_W = 48;

   typedef enum logic [2:0] {
      CIPH_CLEAR   = 3'd0,
      CIPH_WEP40   = 3'd1,
      CIPH_WEP104  = 3'd2,
      CIPH_WEP128  = 3'd3,
      CIPH_TKIP    = 3'd4,
      CIPH_AES_OCB = 3'd5,
      CIPH_AES_CCM = 3'd6
   } cipher_e;

   localparam int ROW_TYPE = 2;
   localparam int ROW_ADDR = 3;
   localparam int PM_BIT   = 3;
   localparam int UNI_BIT  = 15;
   localparam logic [WORD_W-1:0] TYPE_HOST_MASK = 32'h0000_00F7;
   localparam logic [WORD_W-1:0] TYPE_PM_MASK   = 32'h0000_0008;
endpackage

// File: rtl/wkc_pair_stage.sv
module wkc_pair_stage
   import wkc_pkg::*;
#(
   parameter int IDX_W       = 8,
   parameter int NUM_ENTRIES = 128,
   parameter int COMP_OFF    = 64,
   parameter bit COMP_EN     = 1'b1,
   localparam int AW         = $clog2(NUM_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [2:0]        wr_word,
   input  logic [WORD_W-1:0] wr_data,
   output logic              cm_en,
   output logic [AW-1:0]     cm_idx,
   output logic [1:0]        cm_row,
   output logic              cm_lo_ok,
   output logic [ROW_W-1:0]  cm_data,
   output logic              wr_fault
);
   logic              stg_vld;
   logic [AW-1:0]     stg_idx;
   logic [1:0]        stg_row;
   logic [WORD_W-1:0] stg_data;

   logic in_rng, is_odd, pair_ok, tkip_bad;
   logic [AW-1:0] wr_a;

   assign wr_a    = wr_idx[AW-1:0];
   assign in_rng  = (32'(wr_idx) < 32'(NUM_ENTRIES));
   assign is_odd  = wr_word[0];
   assign pair_ok = stg_vld && (stg_idx == wr_a) && (stg_row == wr_word[2:1]);

   generate
      if (COMP_EN) begin : g_comp_chk
         assign tkip_bad = is_odd && (wr_word[2:1] == 2'(ROW_TYPE)) &&
                           (wr_data[2:0] == CIPH_TKIP) &&
                           ((32'(wr_idx) + 32'(COMP_OFF)) >= 32'(NUM_ENTRIES));
      end else begin : g_no_comp_chk
         assign tkip_bad = 1'b0;
      end
   endgenerate

   assign cm_en    = wr_en && is_odd && in_rng && !tkip_bad;
   assign cm_idx   = wr_a;
   assign cm_row   = wr_word[2:1];
   assign cm_lo_ok = pair_ok;
   assign cm_data  = {wr_data, stg_data};
   assign wr_fault = wr_en && (!in_rng || tkip_bad || (is_odd && !pair_ok));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_vld  <= 1'b0;
         stg_idx  <= '0;
         stg_row  <= '0;
         stg_data <= '0;
      end else if (wr_en) begin
         if (is_odd) begin
            stg_vld <= 1'b0;
         end else if (in_rng) begin
            stg_vld  <= 1'b1;
            stg_idx  <= wr_a;
            stg_row  <= wr_word[2:1];
            stg_data <= wr_data;
         end
      end
   end
endmodule

// File: rtl/wkc_store.sv
module wkc_store
   import wkc_pkg::*;
#(
   parameter int IDX_W       = 8,
   parameter int NUM_ENTRIES = 128,
   parameter int COMP_OFF    = 64,
   parameter bit COMP_EN     = 1'b1,
   localparam int AW         = $clog2(NUM_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cm_en,
   input  logic [AW-1:0]     cm_idx,
   input  logic [1:0]        cm_row,
   input  logic              cm_lo_ok,
   input  logic [ROW_W-1:0]  cm_data,
   input  logic              clr_en,
   input  logic [IDX_W-1:0]  clr_idx,
   input  logic              pm_en,
   input  logic [IDX_W-1:0]  pm_idx,
   input  logic              pm_val,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [2:0]        rd_word,
   output logic [WORD_W-1:0] rd_data,
   output logic              clr_fault,
   output logic [2:0]        ent_cipher [NUM_ENTRIES],
   output logic [WORD_W-1:0] ent_lo     [NUM_ENTRIES],
   output logic [15:0]       ent_hi     [NUM_ENTRIES],
   output logic [KEY_W-1:0]  ent_key    [NUM_ENTRIES]
);
   logic [ROW_W-1:0] mem [NUM_ENTRIES][ROWS];

   logic [ROW_W-1:0]  old_row, new_row;
   logic [WORD_W-1:0] new_lo, new_hi;
   logic              clr_ok, pm_ok, rd_ok, clr_comp, was_tkip;
   logic [AW-1:0]     clr_a, pm_a, rd_a, comp_a;
   logic [AW:0]       comp_sum;
   logic [ROW_W-1:0]  rd_row;

   assign clr_a  = clr_idx[AW-1:0];
   assign pm_a   = pm_idx[AW-1:0];
   assign rd_a   = rd_idx[AW-1:0];
   assign clr_ok = (32'(clr_idx) < 32'(NUM_ENTRIES));
   assign pm_ok  = (32'(pm_idx)  < 32'(NUM_ENTRIES));
   assign rd_ok  = (32'(rd_idx)  < 32'(NUM_ENTRIES));
   assign clr_fault = clr_en && !clr_ok;

   assign was_tkip = (mem[clr_a][ROW_TYPE][WORD_W+2:WORD_W] == CIPH_TKIP);
   assign comp_sum = {1'b0, clr_a} + (AW+1)'(COMP_OFF);
   assign comp_a   = comp_sum[AW-1:0];

   generate
      if (COMP_EN) begin : g_comp_clr
         assign clr_comp = clr_en && clr_ok && was_tkip &&
                           (32'(comp_sum) < 32'(NUM_ENTRIES));
      end else begin : g_no_comp_clr
         assign clr_comp = 1'b0;
      end
   endgenerate

   // Merge the committed pair with stored contents and apply field masks.
   always_comb begin
      old_row = mem[cm_idx][cm_row];
      new_lo  = cm_lo_ok ? cm_data[WORD_W-1:0] : old_row[WORD_W-1:0];
      if (cm_row == 2'(ROW_TYPE)) begin
         new_hi = (cm_data[ROW_W-1:WORD_W] & TYPE_HOST_MASK) |
                  (old_row[ROW_W-1:WORD_W] & TYPE_PM_MASK);
      end else begin
         new_hi = {16'h0000, cm_data[WORD_W+15:WORD_W]};
      end
      new_row = {new_hi, new_lo};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < NUM_ENTRIES; e++) begin
            for (int r = 0; r < ROWS; r++) begin
               mem[e][r] <= '0;
            end
         end
      end else begin
         if (cm_en) begin
            mem[cm_idx][cm_row] <= new_row;
         end
         if (pm_en && pm_ok) begin
            mem[pm_a][ROW_TYPE][WORD_W+PM_BIT] <= pm_val;
         end
         if (clr_comp) begin
            mem[comp_a][0] <= '0;
            mem[comp_a][1] <= '0;
            mem[comp_a][ROW_TYPE][WORD_W-1:0] <= '0;
         end
         if (clr_en && clr_ok) begin
            for (int r = 0; r < ROWS; r++) begin
               mem[clr_a][r] <= '0;
            end
         end
      end
   end

   assign rd_row  = mem[rd_a][rd_word[2:1]];
   assign rd_data = !rd_ok ? '0 :
                    (rd_word[0] ? rd_row[ROW_W-1:WORD_W] : rd_row[WORD_W-1:0]);

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_view
      assign ent_cipher[i] = mem[i][ROW_TYPE][WORD_W+2:WORD_W];
      assign ent_lo[i]     = mem[i][ROW_ADDR][WORD_W-1:0];
      assign ent_hi[i]     = mem[i][ROW_ADDR][WORD_W+15:WORD_W];
      assign ent_key[i]    = {mem[i][2][WORD_W-1:0],
                              mem[i][1][WORD_W+15:WORD_W], mem[i][1][WORD_W-1:0],
                              mem[i][0][WORD_W+15:WORD_W], mem[i][0][WORD_W-1:0]};
   end
endmodule

// File: rtl/wkc_lookup.sv
module wkc_lookup
   import wkc_pkg::*;
#(
   parameter int IDX_W       = 8,
   parameter int NUM_ENTRIES = 128,
   parameter int COMP_OFF    = 64,
   parameter bit COMP_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_req,
   input  logic [ADDR_W-1:0] lk_addr,
   input  logic [2:0]        ent_cipher [NUM_ENTRIES],
   input  logic [WORD_W-1:0] ent_lo     [NUM_ENTRIES],
   input  logic [15:0]       ent_hi     [NUM_ENTRIES],
   input  logic [KEY_W-1:0]  ent_key    [NUM_ENTRIES],
   output logic              lk_valid,
   output logic              lk_hit,
   output logic [IDX_W-1:0]  lk_idx,
   output logic [2:0]        lk_cipher,
   output logic [KEY_W-1:0]  lk_key
);
   logic [NUM_ENTRIES-1:0] hit_vec, comp_live;
   logic                   any_hit;
   logic [IDX_W-1:0]       sel_idx;
   logic [2:0]             sel_cipher;
   logic [KEY_W-1:0]       sel_key;

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
      if (COMP_EN && (i >= COMP_OFF)) begin : g_comp
         assign comp_live[i] = (ent_cipher[i-COMP_OFF] == CIPH_TKIP);
      end else begin : g_plain
         assign comp_live[i] = 1'b0;
      end
      assign hit_vec[i] = (ent_cipher[i] != CIPH_CLEAR) &&
                          (ent_lo[i] == lk_addr[32:1]) &&
                          (ent_hi[i][14:0] == lk_addr[47:33]) &&
                          (ent_hi[i][UNI_BIT] == !lk_addr[0]) &&
                          !comp_live[i];
   end

   // Lowest index wins: scan downward so the last assignment is the lowest.
   always_comb begin
      any_hit    = |hit_vec;
      sel_idx    = '0;
      sel_cipher = '0;
      sel_key    = '0;
      for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            sel_idx    = IDX_W'(i);
            sel_cipher = ent_cipher[i];
            sel_key    = ent_key[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_valid  <= 1'b0;
         lk_hit    <= 1'b0;
         lk_idx    <= '0;
         lk_cipher <= '0;
         lk_key    <= '0;
      end else begin
         lk_valid  <= lk_req;
         lk_hit    <= lk_req && any_hit;
         lk_idx    <= lk_req ? sel_idx    : '0;
         lk_cipher <= lk_req ? sel_cipher : '0;
         lk_key    <= lk_req ? sel_key    : '0;
      end
   end
endmodule

// File: rtl/wsec_key_cache.sv
module wsec_key_cache
   import wkc_pkg::*;
#(
   parameter int IDX_W       = 8,
   parameter int NUM_ENTRIES = 128,
   parameter int COMP_OFF    = 64,
   parameter bit COMP_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [2:0]        wr_word,
   input  logic [31:0]       wr_data,
   input  logic              clr_en,
   input  logic [IDX_W-1:0]  clr_idx,
   input  logic              pm_en,
   input  logic [IDX_W-1:0]  pm_idx,
   input  logic              pm_val,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [2:0]        rd_word,
   output logic [31:0]       rd_data,
   input  logic              lk_req,
   input  logic [47:0]       lk_addr,
   output logic              lk_valid,
   output logic              lk_hit,
   output logic [IDX_W-1:0]  lk_idx,
   output logic [2:0]        lk_cipher,
   output logic [127:0]      lk_key,
   output logic              host_fault
);
   localparam int AW = $clog2(NUM_ENTRIES);

   if (NUM_ENTRIES < 2) begin : g_bad_depth
      $error("NUM_ENTRIES must be at least 2");
   end
   if (IDX_W < AW) begin : g_bad_idx
      $error("IDX_W too narrow for NUM_ENTRIES");
   end
   if (COMP_EN && (COMP_OFF < 1 || COMP_OFF >= NUM_ENTRIES)) begin : g_bad_off
      $error("COMP_OFF must lie inside the table");
   end

   logic              wr_go, cm_en, cm_lo_ok, wr_fault, clr_fault;
   logic [AW-1:0]     cm_idx;
   logic [1:0]        cm_row;
   logic [ROW_W-1:0]  cm_data;
   logic [2:0]        ent_cipher [NUM_ENTRIES];
   logic [WORD_W-1:0] ent_lo     [NUM_ENTRIES];
   logic [15:0]       ent_hi     [NUM_ENTRIES];
   logic [KEY_W-1:0]  ent_key    [NUM_ENTRIES];

   assign wr_go = wr_en && !clr_en;

   wkc_pair_stage #(
      .IDX_W(IDX_W), .NUM_ENTRIES(NUM_ENTRIES), .COMP_OFF(COMP_OFF), .COMP_EN(COMP_EN)
   ) u_stage (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_go), .wr_idx(wr_idx), .wr_word(wr_word),
      .wr_data(wr_data), .cm_en(cm_en), .cm_idx(cm_idx), .cm_row(cm_row),
      .cm_lo_ok(cm_lo_ok), .cm_data(cm_data), .wr_fault(wr_fault)
   );

   wkc_store #(
      .IDX_W(IDX_W), .NUM_ENTRIES(NUM_ENTRIES), .COMP_OFF(COMP_OFF), .COMP_EN(COMP_EN)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .cm_en(cm_en), .cm_idx(cm_idx), .cm_row(cm_row),
      .cm_lo_ok(cm_lo_ok), .cm_data(cm_data), .clr_en(clr_en), .clr_idx(clr_idx),
      .pm_en(pm_en), .pm_idx(pm_idx), .pm_val(pm_val), .rd_idx(rd_idx),
      .rd_word(rd_word), .rd_data(rd_data), .clr_fault(clr_fault),
      .ent_cipher(ent_cipher), .ent_lo(ent_lo), .ent_hi(ent_hi), .ent_key(ent_key)
   );

   wkc_lookup #(
      .IDX_W(IDX_W), .NUM_ENTRIES(NUM_ENTRIES), .COMP_OFF(COMP_OFF), .COMP_EN(COMP_EN)
   ) u_lookup (
      .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_addr(lk_addr),
      .ent_cipher(ent_cipher), .ent_lo(ent_lo), .ent_hi(ent_hi), .ent_key(ent_key),
      .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_idx(lk_idx),
      .lk_cipher(lk_cipher), .lk_key(lk_key)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) host_fault <= 1'b0;
      else        host_fault <= wr_fault || clr_fault;
   end
endmodule

// File: rtl/wsec_key_cache_chk.sv
module wsec_key_cache_chk #(
   parameter int IDX_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             clr_en,
   input logic             lk_req,
   input logic             lk_valid,
   input logic             lk_hit,
   input logic [IDX_W-1:0] lk_idx,
   input logic [2:0]       lk_cipher,
   input logic [127:0]     lk_key,
   input logic             host_fault
);
   // R9
   lk_valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> lk_valid);
   // R9
   lk_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |=> !lk_valid);
   // R11
   miss_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_key == '0 && lk_idx == '0 && lk_cipher == '0));
   // R8
   hit_not_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_valid && lk_cipher != 3'd0));
   // R5
   fault_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_fault |-> $past(wr_en || clr_en));
endmodule

bind wsec_key_cache wsec_key_cache_chk #(.IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .clr_en(clr_en), .lk_req(lk_req),
   .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_cipher(lk_cipher),
   .lk_key(lk_key), .host_fault(host_fault)
);

// File: tb/wsec_key_cache_tb.sv
module wsec_key_cache_tb;
   localparam int IDX_W = 8;
   localparam int N     = 128;
   localparam int OFF   = 64;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0, clr_en = 1'b0, pm_en = 1'b0, pm_val = 1'b0, lk_req = 1'b0;
   logic [IDX_W-1:0] wr_idx = '0, clr_idx = '0, pm_idx = '0, rd_idx = '0;
   logic [2:0]       wr_word = '0, rd_word = '0;
   logic [31:0]      wr_data = '0;
   logic [47:0]      lk_addr = '0;
   logic [31:0]      rd_data;
   logic             lk_valid, lk_hit, host_fault;
   logic [IDX_W-1:0] lk_idx;
   logic [2:0]       lk_cipher;
   logic [127:0]     lk_key;

   int n_chk = 0, n_fail = 0;

   // Bench model of the committed words and the staging register.
   logic [31:0] m [N][8];
   logic        s_vld = 1'b0;
   int          s_idx = 0, s_row = 0;
   logic [31:0] s_dat = '0;

   logic [47:0] pool [8];

   always #5 clk = ~clk;

   wsec_key_cache #(.IDX_W(IDX_W), .NUM_ENTRIES(N), .COMP_OFF(OFF), .COMP_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word),
      .wr_data(wr_data), .clr_en(clr_en), .clr_idx(clr_idx), .pm_en(pm_en),
      .pm_idx(pm_idx), .pm_val(pm_val), .rd_idx(rd_idx), .rd_word(rd_word),
      .rd_data(rd_data), .lk_req(lk_req), .lk_addr(lk_addr), .lk_valid(lk_valid),
      .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_cipher(lk_cipher), .lk_key(lk_key),
      .host_fault(host_fault)
   );

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] odd_mask(input int row, input logic [31:0] d,
                                            input logic [31:0] old);
      if (row == 2) return (d & 32'h0000_00F7) | (old & 32'h0000_0008);
      return d & 32'h0000_FFFF;
   endfunction

   // Apply one host write to the model; return the expected fault.
   function automatic bit model_wr(input int idx, input int word, input logic [31:0] d);
      bit in_rng, odd, tbad, pair;
      int row;
      in_rng = idx < N;
      odd    = word[0];
      row    = word >> 1;
      tbad   = odd && row == 2 && d[2:0] == 3'd4 && (idx + OFF >= N);
      pair   = s_vld && s_idx == idx && s_row == row;
      if (odd) begin
         if (in_rng && !tbad) begin
            if (pair) m[idx][2*row] = s_dat;
            m[idx][2*row+1] = odd_mask(row, d, m[idx][2*row+1]);
         end
         s_vld = 1'b0;
      end else if (in_rng) begin
         s_vld = 1'b1; s_idx = idx; s_row = row; s_dat = d;
      end
      return !in_rng || tbad || (odd && !pair);
   endfunction

   function automatic bit model_clr(input int idx);
      bit tk;
      if (idx >= N) return 1'b1;
      tk = (m[idx][5][2:0] == 3'd4);
      for (int w = 0; w < 8; w++) m[idx][w] = '0;
      if (tk && idx + OFF < N)
         for (int w = 0; w < 5; w++) m[idx+OFF][w] = '0;
      return 1'b0;
   endfunction

   task automatic host_wr(input int idx, input int word, input logic [31:0] d,
                          input string req);
      bit ef;
      @(negedge clk);
      wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_word = 3'(word); wr_data = d;
      ef = model_wr(idx, word, d);
      @(negedge clk);
      wr_en = 1'b0;
      chk(host_fault == ef, req, 128'(host_fault), 128'(ef));
   endtask

   task automatic host_clr(input int idx, input string req);
      bit ef;
      @(negedge clk);
      clr_en = 1'b1; clr_idx = IDX_W'(idx);
      ef = model_clr(idx);
      @(negedge clk);
      clr_en = 1'b0;
      chk(host_fault == ef, req, 128'(host_fault), 128'(ef));
   endtask

   task automatic host_pm(input int idx, input bit v);
      @(negedge clk);
      pm_en = 1'b1; pm_idx = IDX_W'(idx); pm_val = v;
      if (idx < N) m[idx][5][3] = v;
      @(negedge clk);
      pm_en = 1'b0;
   endtask

   task automatic check_rd(input int idx, input int word, input logic [31:0] exp,
                           input string req);
      rd_idx = IDX_W'(idx); rd_word = 3'(word);
      #1;
      chk(rd_data == exp, req, 128'(rd_data), 128'(exp));
   endtask

   task automatic check_entry(input int idx, input string req);
      for (int w = 0; w < 8; w++) check_rd(idx, w, m[idx][w], req);
   endtask

   task automatic write_entry(input int idx, input int ciph, input logic [47:0] mac,
                              input bit uni, input string req);
      logic [31:0] ty;
      ty = $urandom();
      ty[2:0] = 3'(ciph);
      host_wr(idx, 0, $urandom(), req); host_wr(idx, 1, $urandom(), req);
      host_wr(idx, 2, $urandom(), req); host_wr(idx, 3, $urandom(), req);
      host_wr(idx, 4, $urandom(), req); host_wr(idx, 5, ty, req);
      host_wr(idx, 6, mac[32:1], req);
      host_wr(idx, 7, {$urandom_range(0, 65535), uni, mac[47:33]}, req);
   endtask

   task automatic model_lk(input logic [47:0] a, output bit hit, output int idx,
                           output logic [2:0] ci, output logic [127:0] key);
      hit = 0; idx = 0; ci = '0; key = '0;
      for (int i = 0; i < N; i++) begin
         if (!hit && m[i][5][2:0] != 3'd0 && m[i][6] == a[32:1] &&
             m[i][7][14:0] == a[47:33] && m[i][7][15] == !a[0] &&
             !(i >= OFF && m[i-OFF][5][2:0] == 3'd4)) begin
            hit = 1; idx = i; ci = m[i][5][2:0];
            key = {m[i][4], m[i][3][15:0], m[i][2], m[i][1][15:0], m[i][0]};
         end
      end
   endtask

   task automatic do_lk(input logic [47:0] a, input string req);
      bit eh; int ei; logic [2:0] ec; logic [127:0] ek;
      model_lk(a, eh, ei, ec, ek);
      @(negedge clk);
      lk_req = 1'b1; lk_addr = a;
      @(negedge clk);
      lk_req = 1'b0;
      chk(lk_valid == 1'b1, req, 128'(lk_valid), 128'(1));
      chk(lk_hit == eh, req, 128'(lk_hit), 128'(eh));
      chk(lk_idx == IDX_W'(ei), req, 128'(lk_idx), 128'(ei));
      chk(lk_cipher == ec, req, 128'(lk_cipher), 128'(ec));
      chk(lk_key == ek, req, lk_key, ek);
   endtask

   function automatic logic [47:0] entry_addr(input int i);
      return {m[i][7][14:0], m[i][6], !m[i][7][15]};
   endfunction

   initial begin
      #1_500_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [47:0] a;
      void'($urandom(32'd20240611));
      for (int i = 0; i < N; i++) for (int w = 0; w < 8; w++) m[i][w] = '0;
      for (int p = 0; p < 8; p++) pool[p] = {$urandom(), 16'($urandom())};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R13 reset state
      check_entry(0, "R13");
      check_entry(N-1, "R13");
      chk(host_fault == 1'b0, "R13", 128'(host_fault), 128'(0));
      do_lk(48'h0, "R13");
      do_lk(pool[0], "R13");

      // R1 even word only stages; odd commits both halves
      host_wr(3, 0, 32'hDEAD_BEEF, "R1");
      check_rd(3, 0, 32'h0, "R1");
      host_wr(3, 1, 32'h0000_1234, "R1");
      check_rd(3, 0, 32'hDEAD_BEEF, "R1");
      check_rd(3, 1, 32'h0000_1234, "R1");

      // R2 orphan odd word
      host_wr(5, 2, 32'h1111_2222, "R2");
      host_wr(6, 3, 32'h0000_AAAA, "R2");
      host_wr(5, 3, 32'h0000_5555, "R2");
      check_rd(5, 2, 32'h0, "R2");
      check_rd(5, 3, 32'h0000_5555, "R2");

      // R3 field masks
      host_wr(7, 0, 32'h0, "R3"); host_wr(7, 1, 32'hFFFF_FFFF, "R3");
      check_rd(7, 1, 32'h0000_FFFF, "R3");
      host_wr(7, 4, 32'h0, "R3"); host_wr(7, 5, 32'hFFFF_FFF1, "R3");
      check_rd(7, 5, 32'h0000_00F1, "R3");
      host_wr(7, 6, 32'h0, "R3"); host_wr(7, 7, 32'hABCD_8001, "R3");
      check_rd(7, 7, 32'h0000_8001, "R3");

      // R4 power-management bit owned by pm port
      host_pm(9, 1'b1);
      check_rd(9, 5, 32'h0000_0008, "R4");
      host_wr(9, 4, 32'h0, "R4"); host_wr(9, 5, 32'h0000_00A2, "R4");
      check_rd(9, 5, 32'h0000_00AA, "R4");
      host_wr(9, 4, 32'h0, "R4"); host_wr(9, 5, 32'h0000_0006, "R4");
      check_rd(9, 5, 32'h0000_000E, "R4");

      // R5 out-of-range commands
      host_wr(200, 0, 32'h1, "R5"); host_wr(200, 1, 32'h1, "R5");
      host_clr(130, "R5");
      check_rd(200, 0, 32'h0, "R5");
      check_entry(72, "R5");

      // R6 TKIP without room for a companion
      host_wr(100, 4, 32'h7777_7777, "R6"); host_wr(100, 5, 32'h0000_0004, "R6");
      check_rd(100, 4, 32'h0, "R6");
      check_rd(100, 5, 32'h0, "R6");

      // R7 clear of a TKIP entry also wipes companion keys
      write_entry(10, 4, pool[1], 1'b1, "R7");
      write_entry(10 + OFF, 0, 48'h0, 1'b0, "R7");
      host_wr(10 + OFF, 4, 32'h0, "R7"); host_wr(10 + OFF, 5, 32'h0000_0050, "R7");
      host_pm(10, 1'b1);
      host_clr(10, "R7");
      for (int w = 0; w < 8; w++) check_rd(10, w, 32'h0, "R7");
      for (int w = 0; w < 5; w++) check_rd(10 + OFF, w, 32'h0, "R7");
      check_rd(10 + OFF, 5, 32'h0000_0050, "R7");

      // R10 companion exclusion
      write_entry(20, 4, pool[2], 1'b1, "R10");
      write_entry(20 + OFF, 1, pool[3], 1'b1, "R10");
      do_lk(entry_addr(20 + OFF), "R10");
      chk(lk_hit == 1'b0, "R10", 128'(lk_hit), 128'(0));
      host_wr(20, 4, 32'h0, "R10"); host_wr(20, 5, 32'h0000_0001, "R10");
      do_lk(entry_addr(20 + OFF), "R10");
      chk(lk_hit && lk_idx == IDX_W'(20 + OFF), "R10", 128'(lk_idx), 128'(20 + OFF));

      // R9 lowest index wins
      write_entry(40, 6, pool[4], 1'b1, "R9");
      write_entry(30, 5, pool[4], 1'b1, "R9");
      do_lk(entry_addr(40), "R9");
      chk(lk_idx == IDX_W'(30), "R9", 128'(lk_idx), 128'(30));

      // R8 group vs unicast flag
      write_entry(50, 2, pool[5], 1'b0, "R8");
      a = {pool[5][47:1], 1'b1};
      do_lk(a, "R8");
      chk(lk_hit == 1'b1, "R8", 128'(lk_hit), 128'(1));
      a = {pool[5][47:1], 1'b0};
      do_lk(a, "R8");
      chk(lk_hit == 1'b0, "R8", 128'(lk_hit), 128'(0));

      // R11 miss outputs
      do_lk(48'hFFFF_FFFF_FFFE, "R11");
      chk(lk_key == '0 && lk_idx == '0, "R11", lk_key, 128'(0));

      // R12 clear and write together: write dropped
      @(negedge clk);
      clr_en = 1'b1; clr_idx = IDX_W'(50);
      wr_en = 1'b1; wr_idx = IDX_W'(51); wr_word = 3'd0; wr_data = 32'h1234_5678;
      void'(model_clr(50));
      @(negedge clk);
      clr_en = 1'b0; wr_en = 1'b0;
      host_wr(51, 1, 32'h0000_0001, "R12");
      check_rd(51, 0, 32'h0, "R12");
      check_entry(50, "R12");

      // Random mix
      for (int it = 0; it < 300; it++) begin
         int op, idx;
         op = $urandom_range(0, 9);
         if (op <= 3) begin
            idx = ($urandom_range(0, 15) == 0) ? $urandom_range(N, 255) : $urandom_range(0, N-1);
            write_entry(idx, $urandom_range(0, 6), pool[$urandom_range(0, 7)],
                        1'($urandom_range(0, 1)), "R1");
            if (idx < N) check_entry(idx, "R3");
         end else if (op <= 6) begin
            do_lk(entry_addr($urandom_range(0, N-1)), "R9");
         end else if (op == 7) begin
            do_lk({pool[$urandom_range(0, 7)][47:1], 1'($urandom_range(0, 1))}, "R8");
         end else if (op == 8) begin
            idx = $urandom_range(0, N+3);
            host_clr(idx, "R7");
            if (idx < N) check_entry(idx, "R7");
         end else begin
            idx = $urandom_range(0, N-1);
            host_pm(idx, 1'($urandom_range(0, 1)));
            check_rd(idx, 5, m[idx][5], "R4");
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule